// File: doc/BRIEF.md
# In-Flight Cache Request Tracker

This block sits between a processor port and its cache controller and keeps account of every cache request still waiting for an answer. Requests are split into two classes: read-class (plain loads and instruction fetches) and write-class (everything that needs exclusive ownership of the line: stores, atomics, linked and conditional operations, read-modify-write halves and flushes). Each class has its own small fully associative table keyed by the cache-line address. In the same cycle that it is presented, each new request gets one of four answers: issued, aliased with a line that already has a request in flight, refused because no room is left, or illegal.

An accepted request is stored with its kind and a timestamp from a free-running cycle counter. A completion input names a class and a line. It retires the matching entry and, one cycle later, reports the miss latency and the kind of the retired request. Four stall counters record which class of request was held back by which class of in-flight entry. An age watchdog runs periodically while work is outstanding and raises a sticky deadlock flag, with the line address, when any entry has waited too long. A completion that matches nothing raises a sticky protocol-error flag.

Top module: `mem_req_tracker`

## Requirements
- R1: Request kind codes are 0 load, 1 instruction fetch, 2 store, 3 atomic, 4 read-modify-write read, 5 read-modify-write write, 6 linked load, 7 conditional store, 8 locked read-modify-write read, 9 locked read-modify-write write and 10 flush. Codes 0 and 1 go to the read-class table and codes 2 to 10 go to the write-class table.
- R2: A request with a kind code of 11 to 15, or whose line offset (the low log2(LINE_BYTES) address bits) plus size exceeds LINE_BYTES, gets status 3 (illegal). It records nothing and bumps no counter. An offset plus size exactly equal to LINE_BYTES is legal.
- R3: A legal request whose line matches a live write-class entry gets status 1 (aliased). It bumps `wstall_rd` when the request is a load, an instruction fetch or a read-modify-write read, and bumps `wstall_wr` otherwise. The write-class table is checked before the read-class table.
- R4: Otherwise, a legal request whose line matches a live read-class entry gets status 1. It bumps `rstall_wr` when the request is a store or a read-modify-write write, and bumps `rstall_rd` otherwise.
- R5: A legal, non-aliased request gets status 2 (full) when the outstanding count is at least MAX_OUT or when its own table has no free entry. Nothing is recorded.
- R6: Any other request gets status 0 (issued) and is recorded with its kind and the current cycle count. `out_cnt` shows it after the next clock edge.
- R7: `out_cnt` always equals the read-table occupancy plus the write-table occupancy and never exceeds MAX_OUT.
- R8: A completion with a matching entry in the selected table retires that entry. In the following cycle, `miss_valid` pulses with `miss_latency` equal to the number of clock edges from the issuing edge to the completing edge, and with the retired kind. A latency of zero is never reported.
- R9: A completion with no matching entry in the selected table sets the sticky `proto_err` flag and changes no table.
- R10: The watchdog is armed by an accepted request when it is idle and checks all entries every DL_THRESH cycles. It re-arms only while entries remain outstanding. When an entry's age reaches DL_THRESH, `deadlock` rises and stays high, and `dl_line` shows that line (read table first, lowest slot first). A lone request never trips the watchdog sooner than DL_THRESH cycles after it is issued.
- R11: A request and a completion in the same cycle both take effect. Alias and room checks use the table contents from before the completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | New request present |
| req_kind | input | 4 | Request kind code (R1) |
| req_addr | input | ADDR_W (16) | Byte address of the request |
| req_size | input | OFF_W+1 (5) | Access size in bytes |
| req_status | output | 2 | Combinational answer: 0 issued, 1 aliased, 2 full, 3 illegal |
| cpl_valid | input | 1 | Completion present |
| cpl_write | input | 1 | Completion targets the write-class table |
| cpl_line | input | LINE_W (12) | Line address being completed |
| miss_valid | output | 1 | Latency report valid |
| miss_latency | output | TS_W (16) | Cycles from issue to completion |
| miss_kind | output | 4 | Kind of the retired request |
| out_cnt | output | OUT_W (4) | Requests in flight |
| wstall_rd | output | STALL_W (16) | Read-like requests aliased on write-class entries |
| wstall_wr | output | STALL_W (16) | Other requests aliased on write-class entries |
| rstall_wr | output | STALL_W (16) | Store-like requests aliased on read-class entries |
| rstall_rd | output | STALL_W (16) | Other requests aliased on read-class entries |
| proto_err | output | 1 | Sticky unmatched-completion flag |
| deadlock | output | 1 | Sticky watchdog flag |
| dl_line | output | LINE_W (12) | Line of the first entry found too old |

## Verification
The assertions check on every cycle that the in-flight count matches both table occupancies and stays within its limit. They also check that a rejected request leaves the count unchanged, that an issued one raises it by exactly one, that reported latencies are never zero, and that both error flags are sticky. How each request is classified, how the aliasing counters split, which status wins when several conditions apply, the exact latency values, and when the watchdog fires relative to the threshold all depend on request history. Only the bench's scenarios can show these: directed fills, aliasing sequences and completion timing, plus a long random run compared against a reference model.

// File: rtl/mrt_pkg.sv
package mrt_pkg;

    localparam int KIND_W = 4;

    localparam logic [KIND_W-1:0] K_LOAD    = 4'd0;
    localparam logic [KIND_W-1:0] K_IFETCH  = 4'd1;
    localparam logic [KIND_W-1:0] K_STORE   = 4'd2;
    localparam logic [KIND_W-1:0] K_RMW_RD  = 4'd4;
    localparam logic [KIND_W-1:0] K_RMW_WR  = 4'd5;
    localparam logic [KIND_W-1:0] K_LAST    = 4'd10;

    typedef enum logic [1:0] {
        ST_ISSUED  = 2'd0,
        ST_ALIASED = 2'd1,
        ST_FULL    = 2'd2,
        ST_ILLEGAL = 2'd3
    } req_status_e;

    function automatic logic kind_known(input logic [KIND_W-1:0] k);
        return k <= K_LAST;
    endfunction

    function automatic logic kind_is_write(input logic [KIND_W-1:0] k);
        return kind_known(k) && (k != K_LOAD) && (k != K_IFETCH);
    endfunction

    function automatic logic kind_read_like(input logic [KIND_W-1:0] k);
        return (k == K_LOAD) || (k == K_IFETCH) || (k == K_RMW_RD);
    endfunction

    function automatic logic kind_store_like(input logic [KIND_W-1:0] k);
        return (k == K_STORE) || (k == K_RMW_WR);
    endfunction

endpackage

// File: rtl/mrt_cam.sv
module mrt_cam #(
    parameter int DEPTH  = 4,
    parameter int LINE_W = 12,
    parameter int TS_W   = 16,
    parameter int THRESH = 64,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int OCC_W = $clog2(DEPTH + 1)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [TS_W-1:0]           now,
    input  logic [LINE_W-1:0]         look_line,
    output logic                      look_hit,
    input  logic                      ret_en,
    input  logic [LINE_W-1:0]         ret_line,
    output logic                      ret_hit,
    output logic [TS_W-1:0]           ret_ts,
    output logic [mrt_pkg::KIND_W-1:0] ret_kind,
    input  logic                      ins_en,
    input  logic [LINE_W-1:0]         ins_line,
    input  logic [mrt_pkg::KIND_W-1:0] ins_kind,
    input  logic [TS_W-1:0]           ins_ts,
    output logic                      free_avail,
    output logic [OCC_W-1:0]          occ,
    output logic                      old_any,
    output logic [LINE_W-1:0]         old_line
);
    typedef struct packed {
        logic                       vld;
        logic [LINE_W-1:0]          line;
        logic [mrt_pkg::KIND_W-1:0] kind;
        logic [TS_W-1:0]            ts;
    } entry_t;

    entry_t           ent [DEPTH];
    logic [IDX_W-1:0] ret_idx;
    logic [IDX_W-1:0] free_idx;
    logic [TS_W-1:0]  age;

    always_comb begin
        look_hit   = 1'b0;
        ret_hit    = 1'b0;
        ret_idx    = '0;
        ret_ts     = '0;
        ret_kind   = '0;
        free_avail = 1'b0;
        free_idx   = '0;
        occ        = '0;
        old_any    = 1'b0;
        old_line   = '0;
        age        = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            age = now - ent[i].ts;
            if (ent[i].vld) begin
                occ = occ + OCC_W'(1);
                if (ent[i].line == look_line) look_hit = 1'b1;
                if (ent[i].line == ret_line) begin
                    ret_hit  = 1'b1;
                    ret_idx  = IDX_W'(i);
                    ret_ts   = ent[i].ts;
                    ret_kind = ent[i].kind;
                end
                if (age >= TS_W'(THRESH)) begin
                    old_any  = 1'b1;
                    old_line = ent[i].line;
                end
            end else begin
                free_avail = 1'b1;
                free_idx   = IDX_W'(i);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) ent[i] <= '0;
        end else begin
            if (ret_en && ret_hit) ent[ret_idx].vld <= 1'b0;
            if (ins_en && free_avail)
                ent[free_idx] <= '{vld: 1'b1, line: ins_line, kind: ins_kind, ts: ins_ts};
        end
    end
endmodule

// File: rtl/mrt_watchdog.sv
module mrt_watchdog #(
    parameter int TS_W   = 16,
    parameter int THRESH = 64,
    parameter int LINE_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              arm,
    input  logic              busy_after,
    input  logic              rd_old,
    input  logic [LINE_W-1:0] rd_old_line,
    input  logic              wr_old,
    input  logic [LINE_W-1:0] wr_old_line,
    output logic              deadlock,
    output logic [LINE_W-1:0] dl_line
);
    logic            armed;
    logic [TS_W-1:0] timer;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed    <= 1'b0;
            timer    <= '0;
            deadlock <= 1'b0;
            dl_line  <= '0;
        end else if (armed) begin
            if (timer == TS_W'(THRESH - 1)) begin
                if (!deadlock && (rd_old || wr_old)) begin
                    deadlock <= 1'b1;
                    dl_line  <= rd_old ? rd_old_line : wr_old_line;
                end
                timer <= '0;
                armed <= busy_after;
            end else begin
                timer <= timer + TS_W'(1);
            end
        end else if (arm) begin
            armed <= 1'b1;
            timer <= '0;
        end
    end
endmodule

// File: rtl/mem_req_tracker.sv
module mem_req_tracker
    import mrt_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int LINE_BYTES = 16,
    parameter int RD_DEPTH   = 4,
    parameter int WR_DEPTH   = 4,
    parameter int MAX_OUT    = 6,
    parameter int TS_W       = 16,
    parameter int DL_THRESH  = 64,
    parameter int STALL_W    = 16,
    localparam int OFF_W     = $clog2(LINE_BYTES),
    localparam int LINE_W    = ADDR_W - OFF_W,
    localparam int SIZE_W    = OFF_W + 1,
    localparam int OUT_W     = $clog2(RD_DEPTH + WR_DEPTH + 1),
    localparam int RD_OCC_W  = $clog2(RD_DEPTH + 1),
    localparam int WR_OCC_W  = $clog2(WR_DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  logic [KIND_W-1:0]  req_kind,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [SIZE_W-1:0]  req_size,
    output logic [1:0]         req_status,
    input  logic               cpl_valid,
    input  logic               cpl_write,
    input  logic [LINE_W-1:0]  cpl_line,
    output logic               miss_valid,
    output logic [TS_W-1:0]    miss_latency,
    output logic [KIND_W-1:0]  miss_kind,
    output logic [OUT_W-1:0]   out_cnt,
    output logic [STALL_W-1:0] wstall_rd,
    output logic [STALL_W-1:0] wstall_wr,
    output logic [STALL_W-1:0] rstall_wr,
    output logic [STALL_W-1:0] rstall_rd,
    output logic               proto_err,
    output logic               deadlock,
    output logic [LINE_W-1:0]  dl_line
);
    logic [TS_W-1:0]   cyc_q;
    logic [LINE_W-1:0] req_line;
    logic [OFF_W+1:0]  span;
    logic              illegal, is_wr, accept, retire, ret_hit_sel;
    req_status_e       status;
    logic [OUT_W-1:0]  out_q, out_nxt;

    logic                rd_hit, wr_hit, rd_ret_hit, wr_ret_hit, rd_free, wr_free;
    logic [TS_W-1:0]     rd_ret_ts, wr_ret_ts, ret_ts_sel;
    logic [KIND_W-1:0]   rd_ret_kind, wr_ret_kind;
    logic [RD_OCC_W-1:0] rd_occ;
    logic [WR_OCC_W-1:0] wr_occ;
    logic                rd_old, wr_old;
    logic [LINE_W-1:0]   rd_old_line, wr_old_line;

    assign req_line = req_addr[ADDR_W-1:OFF_W];
    assign span     = (OFF_W+2)'(req_addr[OFF_W-1:0]) + (OFF_W+2)'(req_size);
    assign illegal  = !kind_known(req_kind) || (span > (OFF_W+2)'(LINE_BYTES));
    assign is_wr    = kind_is_write(req_kind);

    always_comb begin
        if (illegal)                               status = ST_ILLEGAL;
        else if (wr_hit || rd_hit)                 status = ST_ALIASED;
        else if (int'(out_q) >= MAX_OUT)           status = ST_FULL;
        else if (is_wr ? !wr_free : !rd_free)      status = ST_FULL;
        else                                       status = ST_ISSUED;
    end

    assign req_status  = status;
    assign accept      = req_valid && (status == ST_ISSUED);
    assign ret_hit_sel = cpl_write ? wr_ret_hit : rd_ret_hit;
    assign retire      = cpl_valid && ret_hit_sel;
    assign ret_ts_sel  = cpl_write ? wr_ret_ts : rd_ret_ts;
    assign out_nxt     = out_q + OUT_W'(accept) - OUT_W'(retire);
    assign out_cnt     = out_q;

    mrt_cam #(.DEPTH(RD_DEPTH), .LINE_W(LINE_W), .TS_W(TS_W), .THRESH(DL_THRESH)) i_rd_cam (
        .clk(clk), .rst(rst), .now(cyc_q),
        .look_line(req_line), .look_hit(rd_hit),
        .ret_en(cpl_valid && !cpl_write), .ret_line(cpl_line),
        .ret_hit(rd_ret_hit), .ret_ts(rd_ret_ts), .ret_kind(rd_ret_kind),
        .ins_en(accept && !is_wr), .ins_line(req_line), .ins_kind(req_kind), .ins_ts(cyc_q),
        .free_avail(rd_free), .occ(rd_occ), .old_any(rd_old), .old_line(rd_old_line)
    );

    mrt_cam #(.DEPTH(WR_DEPTH), .LINE_W(LINE_W), .TS_W(TS_W), .THRESH(DL_THRESH)) i_wr_cam (
        .clk(clk), .rst(rst), .now(cyc_q),
        .look_line(req_line), .look_hit(wr_hit),
        .ret_en(cpl_valid && cpl_write), .ret_line(cpl_line),
        .ret_hit(wr_ret_hit), .ret_ts(wr_ret_ts), .ret_kind(wr_ret_kind),
        .ins_en(accept && is_wr), .ins_line(req_line), .ins_kind(req_kind), .ins_ts(cyc_q),
        .free_avail(wr_free), .occ(wr_occ), .old_any(wr_old), .old_line(wr_old_line)
    );

    mrt_watchdog #(.TS_W(TS_W), .THRESH(DL_THRESH), .LINE_W(LINE_W)) i_wdog (
        .clk(clk), .rst(rst), .arm(accept), .busy_after(out_nxt != '0),
        .rd_old(rd_old), .rd_old_line(rd_old_line),
        .wr_old(wr_old), .wr_old_line(wr_old_line),
        .deadlock(deadlock), .dl_line(dl_line)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cyc_q        <= '0;
            out_q        <= '0;
            miss_valid   <= 1'b0;
            miss_latency <= '0;
            miss_kind    <= '0;
            proto_err    <= 1'b0;
            wstall_rd    <= '0;
            wstall_wr    <= '0;
            rstall_wr    <= '0;
            rstall_rd    <= '0;
        end else begin
            cyc_q        <= cyc_q + TS_W'(1);
            out_q        <= out_nxt;
            miss_valid   <= retire && ((cyc_q - ret_ts_sel) != '0);
            miss_latency <= cyc_q - ret_ts_sel;
            miss_kind    <= cpl_write ? wr_ret_kind : rd_ret_kind;
            if (cpl_valid && !ret_hit_sel) proto_err <= 1'b1;
            if (req_valid && !illegal) begin
                if (wr_hit) begin
                    if (kind_read_like(req_kind)) wstall_rd <= wstall_rd + STALL_W'(1);
                    else                          wstall_wr <= wstall_wr + STALL_W'(1);
                end else if (rd_hit) begin
                    if (kind_store_like(req_kind)) rstall_wr <= rstall_wr + STALL_W'(1);
                    else                           rstall_rd <= rstall_rd + STALL_W'(1);
                end
            end
        end
    end
endmodule

// File: rtl/mrt_checks.sv
module mrt_checks #(
    parameter int OUT_W    = 4,
    parameter int RD_OCC_W = 3,
    parameter int WR_OCC_W = 3,
    parameter int TS_W     = 16,
    parameter int MAX_OUT  = 6
) (
    input logic                clk,
    input logic                rst,
    input logic                req_valid,
    input logic [1:0]          req_status,
    input logic                cpl_valid,
    input logic [OUT_W-1:0]    out_cnt,
    input logic [RD_OCC_W-1:0] rd_occ,
    input logic [WR_OCC_W-1:0] wr_occ,
    input logic                miss_valid,
    input logic [TS_W-1:0]     miss_latency,
    input logic                proto_err,
    input logic                deadlock
);
    // R7
    occ_sum_chk: assert property (@(posedge clk) disable iff (rst)
        int'(out_cnt) == int'(rd_occ) + int'(wr_occ));

    // R7
    out_limit_chk: assert property (@(posedge clk) disable iff (rst)
        int'(out_cnt) <= MAX_OUT);

    // R2, R5
    reject_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_status != 2'd0 && !cpl_valid) |=> out_cnt == $past(out_cnt));

    // R6
    issue_grow_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_status == 2'd0 && !cpl_valid) |=> int'(out_cnt) == int'($past(out_cnt)) + 1);

    // R8
    miss_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
        miss_valid |-> miss_latency != '0);

    // R9
    perr_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        proto_err |=> proto_err);

    // R10
    dl_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        deadlock |=> deadlock);
endmodule

bind mem_req_tracker mrt_checks #(
    .OUT_W(OUT_W), .RD_OCC_W(RD_OCC_W), .WR_OCC_W(WR_OCC_W), .TS_W(TS_W), .MAX_OUT(MAX_OUT)
) i_chk (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_status(req_status),
    .cpl_valid(cpl_valid), .out_cnt(out_cnt), .rd_occ(rd_occ), .wr_occ(wr_occ),
    .miss_valid(miss_valid), .miss_latency(miss_latency),
    .proto_err(proto_err), .deadlock(deadlock)
);

// File: tb/test_mem_req_tracker.sv
module test_mem_req_tracker;
    localparam int RD_D = 4, WR_D = 4, MAXO = 6, THR = 64;

    logic        clk = 1'b0, rst = 1'b1;
    logic        req_valid = 1'b0, cpl_valid = 1'b0, cpl_write = 1'b0;
    logic [3:0]  req_kind = '0;
    logic [15:0] req_addr = '0;
    logic [4:0]  req_size = '0;
    logic [11:0] cpl_line = '0;
    logic [1:0]  req_status;
    logic        miss_valid, proto_err, deadlock;
    logic [15:0] miss_latency, wstall_rd, wstall_wr, rstall_wr, rstall_rd;
    logic [3:0]  miss_kind, out_cnt;
    logic [11:0] dl_line;

    always #5 clk = ~clk;

    mem_req_tracker i_mem_req_tracker (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
        .req_addr(req_addr), .req_size(req_size), .req_status(req_status),
        .cpl_valid(cpl_valid), .cpl_write(cpl_write), .cpl_line(cpl_line),
        .miss_valid(miss_valid), .miss_latency(miss_latency), .miss_kind(miss_kind),
        .out_cnt(out_cnt), .wstall_rd(wstall_rd), .wstall_wr(wstall_wr),
        .rstall_wr(rstall_wr), .rstall_rd(rstall_rd), .proto_err(proto_err),
        .deadlock(deadlock), .dl_line(dl_line)
    );

    int checks = 0, fails = 0;
    bit done = 0;

    // reference model
    bit         rv_m [RD_D];  logic [11:0] rl_m [RD_D]; int rt_m [RD_D]; logic [3:0] rk_m [RD_D];
    bit         wv_m [WR_D];  logic [11:0] wl_m [WR_D]; int wt_m [WR_D]; logic [3:0] wk_m [WR_D];
    int         m_out, m_wsr, m_wsw, m_rsw, m_rsr, now;
    bit         m_perr, exp_miss;
    int         exp_lat;
    logic [3:0] exp_kind;

    task automatic chk(input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    function automatic int rd_find(input logic [11:0] l);
        for (int i = 0; i < RD_D; i++) if (rv_m[i] && rl_m[i] == l) return i;
        return -1;
    endfunction
    function automatic int wr_find(input logic [11:0] l);
        for (int i = 0; i < WR_D; i++) if (wv_m[i] && wl_m[i] == l) return i;
        return -1;
    endfunction
    function automatic int rd_used();
        int n = 0;
        for (int i = 0; i < RD_D; i++) n += int'(rv_m[i]);
        return n;
    endfunction
    function automatic int wr_used();
        int n = 0;
        for (int i = 0; i < WR_D; i++) n += int'(wv_m[i]);
        return n;
    endfunction

    function automatic int exp_status(input logic [3:0] k, input logic [15:0] a, input logic [4:0] sz);
        bit w;
        if (k > 4'd10 || int'(a[3:0]) + int'(sz) > 16) return 3;
        if (wr_find(a[15:4]) >= 0 || rd_find(a[15:4]) >= 0) return 1;
        w = (k >= 4'd2);
        if (m_out >= MAXO) return 2;
        if (w ? (wr_used() == WR_D) : (rd_used() == RD_D)) return 2;
        return 0;
    endfunction

    task automatic clear_model();
        for (int i = 0; i < RD_D; i++) rv_m[i] = 0;
        for (int i = 0; i < WR_D; i++) wv_m[i] = 0;
        m_out = 0; m_wsr = 0; m_wsw = 0; m_rsw = 0; m_rsr = 0;
        m_perr = 0; exp_miss = 0; now = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; req_valid = 0; cpl_valid = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        clear_model();
    endtask

    // one clock cycle: check registered outputs, drive, check status, update model
    task automatic cyc(input bit rv, input logic [3:0] k, input logic [15:0] a, input logic [4:0] sz,
                       input bit cv, input bit cw, input logic [11:0] cl, input string tag);
        int st, idx;
        logic [11:0] ln;
        @(negedge clk);
        chk("R8 miss_valid", int'(miss_valid), int'(exp_miss));
        if (exp_miss) begin
            chk("R8 miss_latency", int'(miss_latency), exp_lat);
            chk("R8 miss_kind", int'(miss_kind), int'(exp_kind));
        end
        chk("R7 out_cnt", int'(out_cnt), m_out);
        chk("R3 wstall_rd", int'(wstall_rd), m_wsr);
        chk("R3 wstall_wr", int'(wstall_wr), m_wsw);
        chk("R4 rstall_wr", int'(rstall_wr), m_rsw);
        chk("R4 rstall_rd", int'(rstall_rd), m_rsr);
        chk("R9 proto_err", int'(proto_err), int'(m_perr));
        req_valid = rv; req_kind = k; req_addr = a; req_size = sz;
        cpl_valid = cv; cpl_write = cw; cpl_line = cl;
        #1;
        st = exp_status(k, a, sz);
        if (rv) chk(tag, int'(req_status), st);
        // model update on pre-state (R11)
        ln = a[15:4];
        if (rv && st == 1) begin
            if (wr_find(ln) >= 0) begin
                if (k == 4'd0 || k == 4'd1 || k == 4'd4) m_wsr++; else m_wsw++;
            end else begin
                if (k == 4'd2 || k == 4'd5) m_rsw++; else m_rsr++;
            end
        end
        exp_miss = 0;
        if (cv) begin
            idx = cw ? wr_find(cl) : rd_find(cl);
            if (idx < 0) m_perr = 1;
            else begin
                exp_miss = 1;
                exp_lat  = cw ? now - wt_m[idx] : now - rt_m[idx];
                exp_kind = cw ? wk_m[idx] : rk_m[idx];
                if (cw) wv_m[idx] = 0; else rv_m[idx] = 0;
                m_out--;
            end
        end
        if (rv && st == 0) begin
            if (k >= 4'd2) begin
                for (int i = 0; i < WR_D; i++)
                    if (!wv_m[i] && !(cv && cw && idx == i)) begin
                        wv_m[i] = 1; wl_m[i] = ln; wt_m[i] = now; wk_m[i] = k; break;
                    end
            end else begin
                for (int i = 0; i < RD_D; i++)
                    if (!rv_m[i] && !(cv && !cw && idx == i)) begin
                        rv_m[i] = 1; rl_m[i] = ln; rt_m[i] = now; rk_m[i] = k; break;
                    end
            end
            m_out++;
        end
        now++;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(0, 4'd0, 16'h0, 5'd1, 0, 0, 12'h0, "idle");
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        clear_model();
        do_reset();
        // reset state
        #1;
        chk("R10 deadlock after reset", int'(deadlock), 0);
        idle(1);

        // R2 illegal kinds and span boundary
        cyc(1, 4'd12, 16'h1000, 5'd1, 0, 0, 0, "R2 bad kind");
        cyc(1, 4'd2, 16'h100C, 5'd8, 0, 0, 0, "R2 span over line");
        cyc(1, 4'd0, 16'h1008, 5'd8, 0, 0, 0, "R2 span exactly line, R6 issued");
        // R4 read-table aliasing
        cyc(1, 4'd2, 16'h1004, 5'd4, 0, 0, 0, "R4 store on live load");
        cyc(1, 4'd1, 16'h1000, 5'd4, 0, 0, 0, "R4 fetch on live load");
        // R3 write-table aliasing
        cyc(1, 4'd10, 16'h2000, 5'd4, 0, 0, 0, "R1 flush issued to write table");
        cyc(1, 4'd4, 16'h2000, 5'd4, 0, 0, 0, "R3 rmw read on live write");
        cyc(1, 4'd7, 16'h2004, 5'd4, 0, 0, 0, "R3 cond store on live write");
        // fill write table: lines 3,4,5 then one more -> full (table)
        cyc(1, 4'd3, 16'h3000, 5'd4, 0, 0, 0, "R6 atomic");
        cyc(1, 4'd6, 16'h4000, 5'd4, 0, 0, 0, "R1 linked load to write table");
        cyc(1, 4'd9, 16'h5000, 5'd4, 0, 0, 0, "R6 locked write");
        cyc(1, 4'd2, 16'h6000, 5'd4, 0, 0, 0, "R5 write table full");
        // count 5, one more load ok -> 6, then count limit
        cyc(1, 4'd0, 16'h7000, 5'd4, 0, 0, 0, "R6 load");
        cyc(1, 4'd1, 16'h8000, 5'd4, 0, 0, 0, "R5 count at max");
        // complete write line 0x200, R11 same-cycle store to freed slot still full on pre-state
        cyc(1, 4'd2, 16'h9000, 5'd4, 1, 1, 12'h200, "R11 full judged before completion");
        cyc(1, 4'd2, 16'h9000, 5'd4, 0, 0, 0, "R6 issued after completion");
        // unmatched completion
        cyc(0, 4'd0, 16'h0, 5'd1, 1, 0, 12'h200, "R9 idle");
        cyc(0, 4'd0, 16'h0, 5'd1, 1, 1, 12'h100, "R9 wrong class");
        // drain
        cyc(0, 4'd0, 16'h0, 5'd1, 1, 0, 12'h100, "R8");
        cyc(0, 4'd0, 16'h0, 5'd1, 1, 1, 12'h300, "R8");
        cyc(0, 4'd0, 16'h0, 5'd1, 1, 1, 12'h400, "R8");
        cyc(0, 4'd0, 16'h0, 5'd1, 1, 1, 12'h500, "R8");
        cyc(0, 4'd0, 16'h0, 5'd1, 1, 0, 12'h700, "R8");
        cyc(0, 4'd0, 16'h0, 5'd1, 1, 1, 12'h900, "R8");
        idle(2);

        // R10 watchdog: request completed early never trips it
        do_reset();
        cyc(1, 4'd0, 16'hA000, 5'd4, 0, 0, 0, "R10 setup");
        idle(10);
        cyc(0, 4'd0, 16'h0, 5'd1, 1, 0, 12'hA00, "R8 latency after idle");
        idle(2 * THR + 4);
        chk("R10 no deadlock after early completion", int'(deadlock), 0);
        // lone stuck request
        cyc(1, 4'd2, 16'hB000, 5'd4, 0, 0, 0, "R10 stuck store");
        idle(THR - 1);
        chk("R10 no deadlock before threshold", int'(deadlock), 0);
        idle(4);
        chk("R10 deadlock after threshold", int'(deadlock), 1);
        chk("R10 dl_line", int'(dl_line), 'hB00);

        // random phase
        do_reset();
        for (int n = 0; n < 3000; n++) begin
            bit rv, cv, cw;
            logic [3:0] k;
            logic [15:0] a;
            logic [4:0] sz;
            logic [11:0] cl;
            int pick;
            rv = ($urandom % 10) < 7;
            k  = 4'($urandom % 12);
            a  = {12'h100 + 12'($urandom % 8), 4'($urandom % 16)};
            sz = 5'(1 + $urandom % 8);
            cv = ($urandom % 10) < 4;
            cw = $urandom % 2;
            cl = '0;
            if (cv) begin
                pick = -1;
                for (int t = 0; t < 8 && pick < 0; t++) begin
                    int j = $urandom % 4;
                    if (cw ? wv_m[j] : rv_m[j]) pick = j;
                end
                if (pick < 0) cv = 0;
                else cl = cw ? wl_m[pick] : rl_m[pick];
            end
            cyc(rv, k, a, sz, cv, cw, cl, "R1 R5 R6 random status");
        end
        idle(2);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule